// File: doc/BRIEF.md
# Overload Fault Timer for a Power-Sourcing Port

This block guards a powered output port once the power-up sequence has begun. It reads a millisecond tick and a few flags that analogue comparators outside the block produce: current above the cut threshold, current limiting active, and pass switch fully on. From these it decides when the port must be shut off. Three timers feed a small state machine. An inrush timer bounds how long the switch may take to turn on. A leaky overload timer counts up at full rate while the current is above the cut threshold and drains at one sixteenth of that rate while it is below. A streak timer trips a high-power port whose current limiter stays engaged too long.

The state machine has five states. IDLE waits for a power-up start strobe and then moves to INRUSH (transition *start*). INRUSH moves to POWERED when the switch reports fully on after the gate ramp (*switch-on*), or to INR_TRIP when the inrush window runs out (*inrush-timeout*). POWERED moves to OVL_TRIP when the leaky timer fills or the high-power streak expires (*overload*). Both trip states are sticky. Every state returns to IDLE on clear (*clear*). The current-limit select output tells the external limiter to use the fixed inrush limit, or the class-dependent limit once the port is POWERED.

Top module: `surge_guard`

## Requirements
- R1: After reset, and on the cycle after any cycle with `clr` high (clear wins over a simultaneous start strobe), `ovl_fault`, `inrush_fault` and `lim_class` are all 0.
- R2: `lim_class` is 0 (inrush limit) from a start strobe in IDLE until the switch-on is accepted, is 1 while POWERED, and is 0 in IDLE and in both trip states.
- R3: `sw_full_on` is ignored during the first 5 ticks after the start strobe (gate ramp). From the 6th tick edge onward it is accepted, and `lim_class` rises on the next cycle.
- R4: If the switch-on has not been accepted when the 75th tick after start arrives, `inrush_fault` is 1 from the next cycle.
- R5: While POWERED, each tick with `over_cut` high raises the overload count by one.
- R6: While POWERED, every 16th tick with `over_cut` low lowers the overload count by one. The count never goes below zero.
- R7: When a tick with `over_cut` high would bring the overload count to 60, `ovl_fault` is 1 from the next cycle.
- R8: With `hi_pwr` high while POWERED, 15 consecutive ticks with `ilim_active` high set `ovl_fault`. Any cycle with `ilim_active` low restarts that streak from zero.
- R9: With `hi_pwr` low, `ilim_active` never causes a fault.
- R10: Both faults are sticky until `clr`, and `pwr_start` has no effect outside IDLE.
- R11: `ovl_fault` and `inrush_fault` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per millisecond |
| over_cut | input | 1 | Output current above the cut threshold |
| ilim_active | input | 1 | Current limiter engaged |
| sw_full_on | input | 1 | Pass switch reports fully on |
| pwr_start | input | 1 | Power-up start strobe |
| hi_pwr | input | 1 | High-power (class 4, extended power) port |
| clr | input | 1 | Clears faults, timers and prescaler |
| ovl_fault | output | 1 | Overcurrent or sustained-limiting fault, sticky |
| inrush_fault | output | 1 | Switch failed to turn on in time, sticky |
| lim_class | output | 1 | 0 selects the inrush limit, 1 the class limit |

## Verification
The assertions assume that `tick` is a clean one-cycle strobe and that all flags are synchronous to `clk`. They place no constraint on how often ticks arrive or how the flags combine. The stimulus drives every input at the falling edge from a fixed-seed generator, and gives ticks, clears and starts varied densities so that every state and timer is reached. Directed sequences then hit the exact tick counts where each timer expires, one tick before each expiry, the decay and zero-floor behaviour, and a streak broken by a single quiet cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [2:0] {
        SG_IDLE     = 3'd0,
        SG_INRUSH   = 3'd1,
        SG_POWERED  = 3'd2,
        SG_OVL_TRIP = 3'd3,
        SG_INR_TRIP = 3'd4
    } sg_state_e;
endpackage

// File: rtl/sg_leaky_timer.sv
// Up-counts on over-threshold ticks, drains at 1/2**DECAY_LOG2 of that rate.
module sg_leaky_timer #(
    parameter int LIMIT      = 60,
    parameter int DECAY_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    input  logic over,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0]         cnt;
    logic [DECAY_LOG2-1:0] pre;

    always_comb begin
        expire = run && !clear && tick && over && (cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            pre <= '0;
        end else if (clear || !run) begin
            cnt <= '0;
            pre <= '0;
        end else if (tick) begin
            if (over) begin
                if (cnt != LAST) begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                pre <= pre + DECAY_LOG2'(1);
                if ((pre == '1) && (cnt != '0)) begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    // R7: the count never reaches the limit itself
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
    // R5: an over-threshold tick below the limit adds exactly one
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && tick && over && (cnt != LAST)) |=> (cnt == $past(cnt) + CW'(1)));
    // R6: a quiet tick never raises the count
    a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !over) |=> (cnt <= $past(cnt)));
    // R6: zero is a floor
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !over && (cnt == '0)) |=> (cnt == '0));
endmodule

// File: rtl/sg_streak_timer.sv
// Counts consecutive ticks while a condition holds; any gap restarts it.
module sg_streak_timer #(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    input  logic active,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_comb begin
        expire = run && !clear && active && tick && (cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run || !active) begin
            cnt <= '0;
        end else if (tick && (cnt != LAST)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R8: a gap in limiting restarts the streak at once
    a_r8_gap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0));
    // R8: the streak count stays below the limit
    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/sg_inrush_timer.sv
// Measures ticks since power-up start; flags end of gate ramp and timeout.
module sg_inrush_timer #(
    parameter int LIMIT = 75,
    parameter int RAMP  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic ramp_done,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_comb begin
        ramp_done = (cnt >= CW'(RAMP));
        expire    = run && !clear && tick && (cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run) begin
            cnt <= '0;
        end else if (tick && (cnt != LAST)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R4: the window count stays below the timeout
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
    // R3: without a tick the window count holds while running
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !tick) |=> (!run || (cnt == $past(cnt))));
endmodule

// File: rtl/surge_guard.sv
module surge_guard #(
    parameter int OVL_LIMIT_TICKS    = 60,
    parameter int DECAY_LOG2         = 4,
    parameter int HP_LIMIT_TICKS     = 15,
    parameter int INRUSH_LIMIT_TICKS = 75,
    parameter int RAMP_TICKS         = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic over_cut,
    input  logic ilim_active,
    input  logic sw_full_on,
    input  logic pwr_start,
    input  logic hi_pwr,
    input  logic clr,
    output logic ovl_fault,
    output logic inrush_fault,
    output logic lim_class
);
    import sg_pkg::*;

    sg_state_e state_q, state_d;

    logic in_inrush, in_powered;
    logic ramp_done, inr_expire, leak_expire, streak_expire;
    logic sw_accept;

    always_comb begin
        in_inrush  = (state_q == SG_INRUSH);
        in_powered = (state_q == SG_POWERED);
        sw_accept  = sw_full_on && ramp_done;
    end

    sg_inrush_timer #(
        .LIMIT (INRUSH_LIMIT_TICKS),
        .RAMP  (RAMP_TICKS)
    ) u_inrush (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .run       (in_inrush),
        .tick      (tick),
        .ramp_done (ramp_done),
        .expire    (inr_expire)
    );

    sg_leaky_timer #(
        .LIMIT      (OVL_LIMIT_TICKS),
        .DECAY_LOG2 (DECAY_LOG2)
    ) u_leaky (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr),
        .run    (in_powered),
        .tick   (tick),
        .over   (over_cut),
        .expire (leak_expire)
    );

    sg_streak_timer #(
        .LIMIT (HP_LIMIT_TICKS)
    ) u_streak (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr),
        .run    (in_powered),
        .tick   (tick),
        .active (ilim_active && hi_pwr),
        .expire (streak_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = SG_IDLE;
        end else begin
            unique case (state_q)
                SG_IDLE: begin
                    if (pwr_start) state_d = SG_INRUSH;
                end
                SG_INRUSH: begin
                    if (sw_accept)       state_d = SG_POWERED;
                    else if (inr_expire) state_d = SG_INR_TRIP;
                end
                SG_POWERED: begin
                    if (leak_expire || streak_expire) state_d = SG_OVL_TRIP;
                end
                SG_OVL_TRIP: state_d = SG_OVL_TRIP;
                SG_INR_TRIP: state_d = SG_INR_TRIP;
                default:     state_d = SG_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ovl_fault    = 1'b0;
        inrush_fault = 1'b0;
        lim_class    = 1'b0;
        unique case (state_q)
            SG_IDLE:     ;
            SG_INRUSH:   ;
            SG_POWERED:  lim_class    = 1'b1;
            SG_OVL_TRIP: ovl_fault    = 1'b1;
            SG_INR_TRIP: inrush_fault = 1'b1;
            default:     ;
        endcase
    end

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovl_fault, inrush_fault, lim_class}));
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!ovl_fault && !inrush_fault && !lim_class));
    a_r10_ovl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_fault && !clr) |=> ovl_fault);
    a_r10_inr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (inrush_fault && !clr) |=> inrush_fault);
    a_r3_sel_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lim_class) |-> $past(sw_full_on));
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inrush_fault) |-> $past(tick));
endmodule

// File: tb/tb_surge_guard.sv
module tb_surge_guard;
    localparam int CLK_PERIOD = 10;
    localparam int OVL_L = 60;
    localparam int HP_L  = 15;
    localparam int INR_L = 75;
    localparam int RAMP  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, over_cut = 0, ilim_active = 0, sw_full_on = 0;
    logic pwr_start = 0, hi_pwr = 0, clr = 0;
    logic ovl_fault, inrush_fault, lim_class;

    int unsigned total = 0;
    int unsigned bad = 0;
    bit finished = 0;

    // bench model of the requirements
    int m_st = 0;   // 0 idle, 1 inrush, 2 powered, 3 ovl trip, 4 inrush trip
    int m_ic = 0, m_oc = 0, m_pre = 0, m_hc = 0;

    surge_guard dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .over_cut(over_cut),
        .ilim_active(ilim_active), .sw_full_on(sw_full_on),
        .pwr_start(pwr_start), .hi_pwr(hi_pwr), .clr(clr),
        .ovl_fault(ovl_fault), .inrush_fault(inrush_fault), .lim_class(lim_class)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_step();
        bit trip;
        if (clr) begin
            m_st = 0; m_ic = 0; m_oc = 0; m_pre = 0; m_hc = 0;
            return;
        end
        case (m_st)
            0: if (pwr_start) begin m_st = 1; m_ic = 0; end
            1: begin
                if (sw_full_on && m_ic >= RAMP) begin
                    m_st = 2; m_oc = 0; m_pre = 0; m_hc = 0;
                end else if (tick) begin
                    if (m_ic == INR_L - 1) m_st = 4;
                    else m_ic++;
                end
            end
            2: begin
                trip = 0;
                if (tick) begin
                    if (over_cut) begin
                        if (m_oc == OVL_L - 1) trip = 1; else m_oc++;
                    end else begin
                        if (m_pre == 15) begin
                            m_pre = 0;
                            if (m_oc > 0) m_oc--;
                        end else m_pre++;
                    end
                end
                if (!(hi_pwr && ilim_active)) m_hc = 0;
                else if (tick) begin
                    if (m_hc == HP_L - 1) trip = 1; else m_hc++;
                end
                if (trip) m_st = 3;
            end
            default: ;
        endcase
    endfunction

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 model lim_class", lim_class, m_st == 2);
        chk("R7 model ovl_fault", ovl_fault, m_st == 3);
        chk("R4 model inrush_fault", inrush_fault, m_st == 4);
        chk("R11 faults exclusive", ovl_fault && inrush_fault, 1'b0);
    endtask

    task automatic idle_inputs();
        tick = 0; over_cut = 0; ilim_active = 0; sw_full_on = 0;
        pwr_start = 0; hi_pwr = 0; clr = 0;
    endtask

    task automatic do_clear();
        idle_inputs(); clr = 1; cyc(); clr = 0;
    endtask

    task automatic power_up(input logic hp);
        do_clear();
        pwr_start = 1; cyc(); pwr_start = 0;
        hi_pwr = hp; tick = 1; sw_full_on = 1;
        for (int i = 0; i < RAMP + 1; i++) cyc();
        sw_full_on = 0; tick = 0;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        idle_inputs();
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk("R1 reset ovl", ovl_fault, 0);
        chk("R1 reset inr", inrush_fault, 0);
        chk("R1 reset lim", lim_class, 0);
        rst_n = 1;
        cyc();

        // R3: switch-on ignored during the gate ramp
        do_clear();
        pwr_start = 1; cyc(); pwr_start = 0;
        chk("R2 inrush limit after start", lim_class, 0);
        tick = 1; sw_full_on = 1;
        for (int i = 0; i < RAMP; i++) cyc();
        chk("R3 ignored during ramp", lim_class, 0);
        cyc();
        chk("R3 accepted after ramp", lim_class, 1);

        // R4: inrush timeout
        do_clear();
        pwr_start = 1; cyc(); pwr_start = 0; tick = 1;
        for (int i = 0; i < INR_L - 1; i++) cyc();
        chk("R4 no fault before 75th tick", inrush_fault, 0);
        cyc();
        chk("R4 fault on 75th tick", inrush_fault, 1);
        chk("R2 inrush trip limit", lim_class, 0);

        // R10: sticky, start ignored
        tick = 0; pwr_start = 1; sw_full_on = 1;
        for (int i = 0; i < 20; i++) cyc();
        chk("R10 inrush fault sticky", inrush_fault, 1);
        pwr_start = 0; sw_full_on = 0;
        clr = 1; pwr_start = 1; cyc(); clr = 0; pwr_start = 0;
        chk("R1 clear wins over start", inrush_fault, 0);
        cyc();
        chk("R1 stays idle after clear+start", lim_class, 0);

        // R5/R7: overload fills in 60 ticks
        power_up(0);
        chk("R2 class limit when powered", lim_class, 1);
        tick = 1; over_cut = 1;
        for (int i = 0; i < OVL_L - 1; i++) cyc();
        chk("R5 no fault at 59", ovl_fault, 0);
        cyc();
        chk("R7 fault at 60", ovl_fault, 1);
        over_cut = 0; pwr_start = 1;
        for (int i = 0; i < 10; i++) cyc();
        pwr_start = 0;
        chk("R10 ovl sticky", ovl_fault, 1);

        // R6: decay by one after 16 quiet ticks
        power_up(0);
        tick = 1; over_cut = 1;
        for (int i = 0; i < OVL_L - 1; i++) cyc();
        over_cut = 0;
        for (int i = 0; i < 16; i++) cyc();
        over_cut = 1; cyc();
        chk("R6 decay gave one tick of slack", ovl_fault, 0);
        cyc();
        chk("R7 fault after refill", ovl_fault, 1);

        // R6: floor at zero
        power_up(0);
        tick = 1; over_cut = 0;
        for (int i = 0; i < 40; i++) cyc();
        over_cut = 1;
        for (int i = 0; i < OVL_L - 1; i++) cyc();
        chk("R6 floor no early fault", ovl_fault, 0);
        cyc();
        chk("R6 floor fault at 60", ovl_fault, 1);

        // R8: streak with a gap
        power_up(1);
        tick = 1; ilim_active = 1;
        for (int i = 0; i < HP_L - 1; i++) cyc();
        ilim_active = 0; tick = 0; cyc();
        tick = 1; ilim_active = 1;
        for (int i = 0; i < HP_L - 1; i++) cyc();
        chk("R8 gap restarted streak", ovl_fault, 0);
        cyc();
        chk("R8 fault at 15th tick", ovl_fault, 1);

        // R9: normal power ignores limiting
        power_up(0);
        tick = 1; ilim_active = 1;
        for (int i = 0; i < 100; i++) cyc();
        chk("R9 no fault without hi_pwr", ovl_fault, 0);
        chk("R9 still powered", lim_class, 1);

        // random phase
        seed = $urandom(32'h5eed_0042);
        for (int seg = 0; seg < 60; seg++) begin
            int over_pct = $urandom_range(0, 100);
            int tick_pct = $urandom_range(20, 100);
            hi_pwr = 1'($urandom_range(0, 1));
            for (int i = 0; i < 600; i++) begin
                tick        = ($urandom_range(0, 99) < tick_pct);
                over_cut    = ($urandom_range(0, 99) < over_pct);
                ilim_active = ($urandom_range(0, 99) < 90) ? ilim_active : ~ilim_active;
                sw_full_on  = ($urandom_range(0, 9) == 0);
                pwr_start   = ($urandom_range(0, 19) == 0);
                clr         = ($urandom_range(0, 399) == 0);
                cyc();
            end
        end
        idle_inputs();
        cyc();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule